// File: doc/BRIEF.md
# Register Rename Mapping Table

This block tracks, for every architectural register, whether it is currently renamed and, if it is, which rename buffer will hold or already holds its newest value. Each architectural register has exactly one entry, indexed by its register number. An entry holds a valid flag and a buffer index. Dispatch write ports set an entry when a rename buffer is allocated to a destination register. A second rename of the same register overwrites the index, so the entry always names the latest allocation.

Read ports translate source register numbers into a renamed flag and a buffer index. When the flag is low, the operand is read from the architectural register file. A completion port retires a mapping when the instruction that created it completes. It clears the entry only when the stored index still matches the completing buffer, so a newer rename survives. A flush input drops every mapping at once, for use after a misprediction.

The block does not provide rename buffer storage, free-list allocation, operand values or same-cycle dependency handling between instructions. Any bypass of a write made in the current cycle is left to the surrounding logic.

Top module: `rename_map_table`

## Requirements
- R1: While reset is asserted and after it is released, every entry is invalid. Every read port reports renamed=0 and index 0.
- R2: A read port combinationally returns renamed=1 and the stored index for a valid entry. It returns renamed=0 and index 0 for an invalid entry. All read ports work independently.
- R3: A dispatch write with wr_en_i set makes the addressed entry valid with the given index, visible on the read ports from the next cycle on.
- R4: A dispatch write to an entry that is already valid replaces its index with the new one.
- R5: A completion whose buffer index equals the stored index of a valid entry makes that entry invalid from the next cycle on.
- R6: A completion whose index differs from the stored one, or that addresses an invalid entry, leaves that entry unchanged.
- R7: When a dispatch write and a completion address the same entry in one cycle, the write takes effect and the entry stays valid with the new index.
- R8: A lookup in the same cycle as a write to the same register returns the mapping from before the write.
- R9: flush_i makes every entry invalid in the next cycle. A dispatch write in the same cycle is discarded.
- R10: When several write ports address the same register in one cycle, the highest-numbered port's index is kept.
- R11: Writes to different registers in the same cycle all take effect. No other entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all mappings |
| wr_en_i | input | NUM_WR | Per-port dispatch write enable |
| wr_areg_i | input | NUM_WR x AREG_W | Destination register number per write port |
| wr_rb_i | input | NUM_WR x RB_W | Allocated buffer index per write port |
| cmp_en_i | input | 1 | Completion valid |
| cmp_areg_i | input | AREG_W | Destination register of completing instruction |
| cmp_rb_i | input | RB_W | Buffer index of completing instruction |
| rd_areg_i | input | NUM_RD x AREG_W | Source register number per read port |
| rd_renamed_o | output | NUM_RD | Entry valid: operand comes from a rename buffer |
| rd_rb_o | output | NUM_RD x RB_W | Buffer index, 0 when not renamed |

## Verification
The bench builds the table with 8 registers, 8 buffers, two write ports and two read ports. With this small table, every entry can be swept after reset and after flush. Two write ports make same-register collisions between ports reachable, so the port priority can be checked. The same build also reaches a stale completion arriving after a re-rename, a completion colliding with a dispatch write, and a lookup racing a write.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  typedef enum logic [1:0] {
    ENT_HOLD   = 2'd0,
    ENT_SET    = 2'd1,
    ENT_RETIRE = 2'd2,
    ENT_FLUSH  = 2'd3
  } ent_act_e;
endpackage

// File: rtl/rmt_entry.sv
module rmt_entry
  import rmt_pkg::*;
#(
  parameter int NUM_WR = 1,
  parameter int AREG_W = 5,
  parameter int RB_W   = 6,
  parameter int IDX    = 0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AREG_W-1:0] wr_areg_i,
  input  logic [NUM_WR-1:0][RB_W-1:0]   wr_rb_i,
  input  logic                          cmp_en_i,
  input  logic [AREG_W-1:0]             cmp_areg_i,
  input  logic [RB_W-1:0]               cmp_rb_i,
  output logic                          valid_o,
  output logic [RB_W-1:0]               rb_o
);
  localparam logic [AREG_W-1:0] MY_REG = AREG_W'(IDX);

  logic [NUM_WR-1:0] wr_hit;
  logic [RB_W-1:0]   wr_rb_sel;
  logic              cmp_hit;
  ent_act_e          act;
  logic              valid_q;
  logic [RB_W-1:0]   rb_q;

  always_comb begin
    wr_hit = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      wr_hit[p] = wr_en_i[p] && (wr_areg_i[p] == MY_REG);
    end
  end

  // highest-numbered hitting port wins
  always_comb begin
    wr_rb_sel = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (wr_hit[p]) wr_rb_sel = wr_rb_i[p];
    end
  end

  assign cmp_hit = cmp_en_i && (cmp_areg_i == MY_REG);

  always_comb begin
    if (flush_i)                                   act = ENT_FLUSH;
    else if (|wr_hit)                              act = ENT_SET;
    else if (cmp_hit && valid_q && rb_q == cmp_rb_i) act = ENT_RETIRE;
    else                                           act = ENT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rb_q    <= '0;
    end else begin
      unique case (act)
        ENT_FLUSH:  valid_q <= 1'b0;
        ENT_RETIRE: valid_q <= 1'b0;
        ENT_SET: begin
          valid_q <= 1'b1;
          rb_q    <= wr_rb_sel;
        end
        default: ;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign rb_o    = rb_q;

  // R9
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_q);

  // R3
  write_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && (|wr_hit)) |=> valid_q);

  // R7
  write_beats_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && (|wr_hit) && cmp_hit) |=> (valid_q && rb_q == $past(wr_rb_sel)));

  // R5
  cmp_match_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !(|wr_hit) && cmp_en_i && cmp_areg_i == MY_REG && valid_q && rb_q == cmp_rb_i)
      |=> !valid_q);

  // R6
  cmp_stale_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !(|wr_hit) && cmp_hit && rb_q != cmp_rb_i)
      |=> ($stable(valid_q) && $stable(rb_q)));
endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port #(
  parameter int NUM_AREGS = 32,
  parameter int AREG_W    = 5,
  parameter int RB_W      = 6
) (
  input  logic [NUM_AREGS-1:0]           valid_i,
  input  logic [NUM_AREGS-1:0][RB_W-1:0] rb_i,
  input  logic [AREG_W-1:0]              areg_i,
  output logic                           renamed_o,
  output logic [RB_W-1:0]                rb_o
);
  always_comb begin
    renamed_o = 1'b0;
    rb_o      = '0;
    for (int r = 0; r < NUM_AREGS; r++) begin
      if (areg_i == AREG_W'(r) && valid_i[r]) begin
        renamed_o = 1'b1;
        rb_o      = rb_i[r];
      end
    end
  end
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_AREGS = 32,
  parameter int NUM_RBS   = 64,
  parameter int NUM_WR    = 1,
  parameter int NUM_RD    = 2,
  parameter int AREG_W    = $clog2(NUM_AREGS),
  parameter int RB_W      = $clog2(NUM_RBS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AREG_W-1:0] wr_areg_i,
  input  logic [NUM_WR-1:0][RB_W-1:0]   wr_rb_i,
  input  logic                          cmp_en_i,
  input  logic [AREG_W-1:0]             cmp_areg_i,
  input  logic [RB_W-1:0]               cmp_rb_i,
  input  logic [NUM_RD-1:0][AREG_W-1:0] rd_areg_i,
  output logic [NUM_RD-1:0]             rd_renamed_o,
  output logic [NUM_RD-1:0][RB_W-1:0]   rd_rb_o
);
  logic [NUM_AREGS-1:0]           ent_valid;
  logic [NUM_AREGS-1:0][RB_W-1:0] ent_rb;

  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_ent
    rmt_entry #(
      .NUM_WR (NUM_WR),
      .AREG_W (AREG_W),
      .RB_W   (RB_W),
      .IDX    (g)
    ) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .wr_en_i    (wr_en_i),
      .wr_areg_i  (wr_areg_i),
      .wr_rb_i    (wr_rb_i),
      .cmp_en_i   (cmp_en_i),
      .cmp_areg_i (cmp_areg_i),
      .cmp_rb_i   (cmp_rb_i),
      .valid_o    (ent_valid[g]),
      .rb_o       (ent_rb[g])
    );
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    rmt_read_port #(
      .NUM_AREGS (NUM_AREGS),
      .AREG_W    (AREG_W),
      .RB_W      (RB_W)
    ) u_rd (
      .valid_i   (ent_valid),
      .rb_i      (ent_rb),
      .areg_i    (rd_areg_i[g]),
      .renamed_o (rd_renamed_o[g]),
      .rb_o      (rd_rb_o[g])
    );
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_renamed_o[0] |-> (rd_rb_o[0] == '0));

  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ent_valid == '0));
endmodule

// File: tb/tb_rename_map_table.sv
`timescale 1ns/1ps
module tb_rename_map_table;
  localparam int CLK_P = 10;
  localparam int NA = 8, NB = 8, NW = 2, NR = 2, AW = 3, BW = 3;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   flush_i = 1'b0;
  logic [NW-1:0]          wr_en_i = '0;
  logic [NW-1:0][AW-1:0]  wr_areg_i = '0;
  logic [NW-1:0][BW-1:0]  wr_rb_i = '0;
  logic                   cmp_en_i = 1'b0;
  logic [AW-1:0]          cmp_areg_i = '0;
  logic [BW-1:0]          cmp_rb_i = '0;
  logic [NR-1:0][AW-1:0]  rd_areg_i = '0;
  logic [NR-1:0]          rd_renamed_o;
  logic [NR-1:0][BW-1:0]  rd_rb_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rename_map_table #(
    .NUM_AREGS (NA), .NUM_RBS (NB), .NUM_WR (NW), .NUM_RD (NR)
  ) dut (
    .clk_i, .rst_ni, .flush_i, .wr_en_i, .wr_areg_i, .wr_rb_i,
    .cmp_en_i, .cmp_areg_i, .cmp_rb_i, .rd_areg_i, .rd_renamed_o, .rd_rb_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic lookup(int p, int areg, int exp_ren, int exp_rb, string req);
    rd_areg_i[p] = AW'(areg);
    #1;
    chk(req, int'(rd_renamed_o[p]), exp_ren);
    chk(req, int'(rd_rb_o[p]), exp_rb);
  endtask

  task automatic drive_wr(int p, int areg, int rb);
    wr_en_i[p]   = 1'b1;
    wr_areg_i[p] = AW'(areg);
    wr_rb_i[p]   = BW'(rb);
  endtask

  task automatic drive_cmp(int areg, int rb);
    cmp_en_i   = 1'b1;
    cmp_areg_i = AW'(areg);
    cmp_rb_i   = BW'(rb);
  endtask

  task automatic commit();
    @(posedge clk_i);
    #1;
    wr_en_i  = '0;
    cmp_en_i = 1'b0;
    flush_i  = 1'b0;
  endtask

  task automatic t_reset();
    for (int r = 0; r < NA; r++) begin
      lookup(0, r, 0, 0, "R1 in reset p0");
      lookup(1, r, 0, 0, "R1 in reset p1");
    end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    commit();
    lookup(0, 5, 0, 0, "R1 after reset");
  endtask

  task automatic t_single();
    drive_wr(0, 3, 5);
    commit();
    lookup(0, 3, 1, 5, "R3 write visible");
    lookup(1, 3, 1, 5, "R2 second port");
    lookup(1, 2, 0, 0, "R2 unmapped");
  endtask

  task automatic t_dual();
    drive_wr(0, 1, 2);
    drive_wr(1, 6, 7);
    commit();
    lookup(0, 1, 1, 2, "R11 port0 reg");
    lookup(1, 6, 1, 7, "R11 port1 reg");
    lookup(0, 3, 1, 5, "R11 other untouched");
    drive_wr(0, 4, 1);
    drive_wr(1, 4, 3);
    commit();
    lookup(0, 4, 1, 3, "R10 higher port wins");
  endtask

  task automatic t_overwrite();
    drive_wr(0, 3, 6);
    commit();
    lookup(0, 3, 1, 6, "R4 rename again");
  endtask

  task automatic t_bypass();
    drive_wr(0, 5, 4);
    drive_wr(1, 3, 2);
    lookup(0, 5, 0, 0, "R8 new reg pre-write");
    lookup(1, 3, 1, 6, "R8 mapped reg pre-write");
    commit();
    lookup(0, 5, 1, 4, "R8 new reg post-write");
    lookup(1, 3, 1, 2, "R8 mapped reg post-write");
  endtask

  task automatic t_complete();
    drive_cmp(3, 6);
    commit();
    lookup(0, 3, 1, 2, "R6 stale index");
    drive_cmp(2, 0);
    commit();
    lookup(0, 2, 0, 0, "R6 unmapped reg");
    lookup(1, 0, 0, 0, "R6 other reg");
    drive_cmp(3, 2);
    commit();
    lookup(0, 3, 0, 0, "R5 match clears");
    lookup(1, 5, 1, 4, "R5 other kept");
  endtask

  task automatic t_collide();
    drive_cmp(1, 2);
    drive_wr(0, 1, 0);
    commit();
    lookup(0, 1, 1, 0, "R7 write beats completion");
  endtask

  task automatic t_flush();
    flush_i = 1'b1;
    drive_wr(1, 7, 1);
    commit();
    for (int r = 0; r < NA; r++) lookup(r % 2, r, 0, 0, "R9 flushed");
    drive_wr(0, 0, 7);
    commit();
    lookup(0, 0, 1, 7, "R3 after flush");
    lookup(1, 7, 0, 0, "R9 dropped write");
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_overwrite();
    t_bypass();
    t_complete();
    t_collide();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule